// File: doc/BRIEF.md
# Sample-Rate Frame Link Between Twin Receiver Chips

This block moves parallel sample words between two identical receiver chips that share one system clock. One chip is built as the master and the other as the slave, chosen by a parameter. The master drives a bit clock, a frame sync pulse and several data lanes. The slave drives one return lane for each master lane. A frame lasts exactly one baseband sample period of 256 system clocks. Each lane carries one bit every 8 clocks, which gives 32 bits per lane per frame, sent most significant bit first.

On both sides the local logic hands over one word per lane at each frame boundary, when `tx_ready` is high. It receives the word that the far side sent, together with a one-cycle `rx_valid` strobe. The width of the sync pulse can be set in bit periods, so its harmonic content can be moved. The slave locks to the spacing of the sync pulses and reports when that spacing breaks.

Top module: `frame_link`

## Requirements
- R1: A frame is 256 system clocks. The master bit clock has a period of 8 clocks and is high for the first 4 clocks after each rising edge. The sync pulse rises in the same cycle as a rising edge of the bit clock, and that edge starts bit 0 of the frame.
- R2: Master data lanes change only in a cycle where the bit clock rises. Each lane sends its 32-bit word most significant bit first, one bit per bit-clock period.
- R3: `sync_width` = w sets the master sync pulse to 8*w clocks, for w from 1 to 31. A value of 0 gives one bit period (8 clocks). A new width takes effect from the frame that follows the next frame boundary.
- R4: `tx_ready` is high for exactly one cycle in every frame, in the frame's last cycle. The value on `tx_words` at that clock edge is sent in the next frame. Lane l uses bits [32*l+31 : 32*l].
- R5: The slave presents each word that the master sent, unchanged and in order, on `rx_words` with the same lane packing. `rx_valid` is high for one cycle per frame.
- R6: The master receives the slave's return words in the same way, unchanged, in order, and marked by `rx_valid`.
- R7: The slave raises `locked` on a sync rising edge that comes exactly 256 clocks after the previous sync rising edge. `rx_valid` is produced only while the side is locked. The master is locked from the end of its first frame onward.
- R8: In the slave, a sync rising edge that comes early or late, or a missing sync edge, clears `locked`. If the slave was locked at that moment, `lock_err` pulses for one cycle. After such an error the slave locks again after two sync edges that are correctly spaced.
- R9: During reset every output is low. This includes `locked`, `tx_ready`, `rx_valid` and the link lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared by both chips |
| rst | input | 1 | Synchronous active-high reset |
| sync_width | input | 5 | Sync pulse width in bit periods (master only) |
| tx_words | input | 96 | Words to send, 32 bits per lane |
| tx_ready | output | 1 | Words on `tx_words` are taken at this edge |
| rx_words | output | 96 | Words received from the far side |
| rx_valid | output | 1 | One-cycle strobe marking new `rx_words` |
| locked | output | 1 | Frame timing is aligned |
| lock_err | output | 1 | Pulse when the sync spacing breaks while locked |
| link_clk_o | output | 1 | Bit clock (master drives it, slave holds it low) |
| link_sync_o | output | 1 | Frame sync (master drives it, slave holds it low) |
| link_data_o | output | 3 | Outgoing data lanes |
| link_sync_i | input | 1 | Frame sync from the master (used by the slave) |
| link_data_i | input | 3 | Data lanes from the far side |

## Verification
The bench connects a master and a slave back to back. A scoreboard follows every word in both directions, so a design that loaded words a frame late, swapped lanes or misaligned the slave's sample point would show up as mismatched words. The serial bits on the master lanes are compared against the loaded word, which catches a bit order that is reversed on both sides and would otherwise cancel out. Sync widths of 0, 1, 5 and 31 are measured: treating 0 literally would give no sync at all, and an off-by-one would change the pulse length by 8 clocks. A dropped sync pulse and an injected early pulse both have to clear the lock and produce exactly one error pulse each. The slave must then lock again without issuing `rx_valid` while it is unlocked, so a monitor that ignored missing edges, or that went back into lock after a single edge, would fail.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;
  // slave alignment states: no edge seen yet, one edge seen, spacing confirmed
  typedef enum logic [1:0] {
    LK_SEARCH = 2'd0,
    LK_ARMED  = 2'd1,
    LK_LOCKED = 2'd2
  } lock_st_t;
endpackage

// File: rtl/frame_link_timer.sv
module frame_link_timer #(
  parameter int FRAME_CLKS = 256,
  localparam int CNT_W = $clog2(FRAME_CLKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             realign,
  output logic [CNT_W-1:0] pos,
  output logic             at_last,
  output logic             next_last
);
  logic [CNT_W-1:0] cnt;

  // a realign pulse makes the current cycle position zero
  assign pos       = realign ? '0 : cnt;
  assign at_last   = (pos == CNT_W'(FRAME_CLKS - 1));
  assign next_last = (pos == CNT_W'(FRAME_CLKS - 2));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= at_last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/frame_link_lane_tx.sv
module frame_link_lane_tx #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic              dout
);
  logic [WORD_W-1:0] hold;
  logic [BIT_W-1:0]  msb_idx;

  // WORD_W is a power of two, so WORD_W-1-bit_idx equals the bitwise inverse
  assign msb_idx = ~bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      dout <= 1'b0;
    end else begin
      if (load) hold <= word;
      dout <= hold[msb_idx];
    end
  end
endmodule

// File: rtl/frame_link_lane_rx.sv
module frame_link_lane_rx #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              shift,
  input  logic              publish,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      word <= '0;
    end else begin
      if (shift)   sh   <= {sh[WORD_W-2:0], din};
      if (publish) word <= sh;
    end
  end
endmodule

// File: rtl/frame_link_lock_mon.sv
module frame_link_lock_mon
  import frame_link_pkg::*;
#(
  parameter int FRAME_CLKS = 256,
  localparam int GAP_W = $clog2(FRAME_CLKS) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_q,
  output logic rise,
  output logic locked,
  output logic lock_err
);
  localparam logic [GAP_W-1:0] GAP_GOOD = GAP_W'(FRAME_CLKS - 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;

  logic             sync_d;
  logic [GAP_W-1:0] gap;
  lock_st_t         st, st_nx;
  logic             gap_ok, bad;

  assign rise   = sync_q & ~sync_d;
  assign gap_ok = (gap == GAP_GOOD);
  // an edge off the 256-clock grid, or no edge where one is due
  assign bad    = (st != LK_SEARCH) && (rise ? !gap_ok : gap_ok);

  always_comb begin
    st_nx = st;
    unique case (st)
      LK_SEARCH: if (rise)           st_nx = LK_ARMED;
      LK_ARMED:  if (rise && gap_ok) st_nx = LK_LOCKED;
      LK_LOCKED: if (bad)            st_nx = LK_ARMED;
      default:                       st_nx = LK_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d   <= 1'b0;
      gap      <= '0;
      st       <= LK_SEARCH;
      lock_err <= 1'b0;
    end else begin
      sync_d   <= sync_q;
      gap      <= rise ? '0 : ((gap == GAP_MAX) ? gap : gap + 1'b1);
      st       <= st_nx;
      lock_err <= (st == LK_LOCKED) && bad;
    end
  end

  assign locked = (st == LK_LOCKED);
endmodule

// File: rtl/frame_link.sv
module frame_link #(
  parameter bit IS_MASTER  = 1'b1,
  parameter int LANES      = 3,
  parameter int FRAME_CLKS = 256,
  parameter int BIT_CLKS   = 8,
  localparam int WORD_W = FRAME_CLKS / BIT_CLKS,
  localparam int CNT_W  = $clog2(FRAME_CLKS),
  localparam int PH_W   = $clog2(BIT_CLKS),
  localparam int BIT_W  = CNT_W - PH_W,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BIT_W-1:0]  sync_width,
  input  logic [DATA_W-1:0] tx_words,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_words,
  output logic              rx_valid,
  output logic              locked,
  output logic              lock_err,
  output logic              link_clk_o,
  output logic              link_sync_o,
  output logic [LANES-1:0]  link_data_o,
  input  logic              link_sync_i,
  input  logic [LANES-1:0]  link_data_i
);
  // master samples return data later: it arrives after a round trip
  localparam int SAMPLE_PH = IS_MASTER ? (BIT_CLKS * 3 / 4) : (BIT_CLKS / 2);

  logic [CNT_W-1:0] pos;
  logic             at_last, next_last, realign;
  logic [BIT_W-1:0] bit_idx;
  logic [PH_W-1:0]  phase;
  logic [LANES-1:0] data_q;
  logic             link_locked, link_err, sample_now;

  frame_link_timer #(.FRAME_CLKS(FRAME_CLKS)) timer_i (
    .clk(clk), .rst(rst), .realign(realign),
    .pos(pos), .at_last(at_last), .next_last(next_last)
  );

  assign bit_idx    = pos[CNT_W-1:PH_W];
  assign phase      = pos[PH_W-1:0];
  assign sample_now = (phase == PH_W'(SAMPLE_PH));

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= link_data_i;
  end

  if (IS_MASTER) begin : g_master
    logic [BIT_W-1:0] width_q;
    logic             clk_r, sync_r, mlock;
    logic             unused_sync;

    assign unused_sync = link_sync_i;
    assign realign     = 1'b0;

    always_ff @(posedge clk) begin
      if (rst) begin
        width_q <= BIT_W'(1);
        clk_r   <= 1'b0;
        sync_r  <= 1'b0;
        mlock   <= 1'b0;
      end else begin
        if (at_last) begin
          width_q <= (sync_width == '0) ? BIT_W'(1) : sync_width;
          mlock   <= 1'b1;
        end
        clk_r  <= (phase < PH_W'(BIT_CLKS / 2));
        sync_r <= (bit_idx < width_q);
      end
    end

    assign link_clk_o  = clk_r;
    assign link_sync_o = sync_r;
    assign link_locked = mlock;
    assign link_err    = 1'b0;
  end else begin : g_slave
    logic             sync_q, rise;
    logic [BIT_W-1:0] unused_width;

    assign unused_width = sync_width;

    always_ff @(posedge clk) begin
      if (rst) sync_q <= 1'b0;
      else     sync_q <= link_sync_i;
    end

    frame_link_lock_mon #(.FRAME_CLKS(FRAME_CLKS)) lock_i (
      .clk(clk), .rst(rst), .sync_q(sync_q),
      .rise(rise), .locked(link_locked), .lock_err(link_err)
    );

    assign realign     = rise;
    assign link_clk_o  = 1'b0;
    assign link_sync_o = 1'b0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    frame_link_lane_tx #(.WORD_W(WORD_W)) tx_i (
      .clk(clk), .rst(rst), .load(at_last),
      .word(tx_words[l*WORD_W +: WORD_W]), .bit_idx(bit_idx),
      .dout(link_data_o[l])
    );
    frame_link_lane_rx #(.WORD_W(WORD_W)) rx_i (
      .clk(clk), .rst(rst), .din(data_q[l]), .shift(sample_now),
      .publish(at_last && link_locked),
      .word(rx_words[l*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ready <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      tx_ready <= next_last;
      rx_valid <= at_last && link_locked;
    end
  end

  assign locked   = link_locked;
  assign lock_err = link_err;
endmodule

// File: rtl/frame_link_chk.sv
module frame_link_chk #(
  parameter bit IS_MASTER = 1'b1,
  parameter int LANES     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             link_clk_o,
  input logic             link_sync_o,
  input logic [LANES-1:0] link_data_o,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             locked,
  input logic             lock_err
);
  if (IS_MASTER) begin : g_m
    assert_sync_on_clk_rise_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(link_sync_o) |-> $rose(link_clk_o));
    assert_data_on_clk_rise_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(link_data_o) |-> $rose(link_clk_o));
  end

  assert_ready_single_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_valid_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(locked));
  assert_err_clears_lock_R8: assert property (@(posedge clk) disable iff (rst)
    lock_err |-> !locked);
endmodule

bind frame_link frame_link_chk #(.IS_MASTER(IS_MASTER), .LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .link_clk_o(link_clk_o), .link_sync_o(link_sync_o),
  .link_data_o(link_data_o), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .locked(locked), .lock_err(lock_err)
);

// File: tb/frame_link_tb_top.sv
module frame_link_tb_top;
  localparam int LANES = 3;
  localparam int WW    = 32;
  localparam int BW    = 5;
  localparam int DW    = LANES * WW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [BW-1:0]    width_m;
  logic [DW-1:0]    m_tx = '0, s_tx = '0;
  logic [DW-1:0]    m_rx, s_rx;
  logic             m_ready, s_ready, m_valid, s_valid, m_lock, s_lock, m_err, s_err;
  logic             m_clk, m_sync, s_clk, s_sync;
  logic [LANES-1:0] m_data, s_data;
  logic             kill = 1'b0, inj = 1'b0;
  logic             sync_to_s;
  assign sync_to_s = (m_sync & ~kill) | inj;

  frame_link #(.IS_MASTER(1'b1)) dut_i (
    .clk(clk), .rst(rst), .sync_width(width_m), .tx_words(m_tx), .tx_ready(m_ready),
    .rx_words(m_rx), .rx_valid(m_valid), .locked(m_lock), .lock_err(m_err),
    .link_clk_o(m_clk), .link_sync_o(m_sync), .link_data_o(m_data),
    .link_sync_i(1'b0), .link_data_i(s_data)
  );

  frame_link #(.IS_MASTER(1'b0)) slave_i (
    .clk(clk), .rst(rst), .sync_width('0), .tx_words(s_tx), .tx_ready(s_ready),
    .rx_words(s_rx), .rx_valid(s_valid), .locked(s_lock), .lock_err(s_err),
    .link_clk_o(s_clk), .link_sync_o(s_sync), .link_data_o(s_data),
    .link_sync_i(sync_to_s), .link_data_i(m_data)
  );

  int n_checks = 0, n_fail = 0;
  int m_cmp = 0, s_cmp = 0, err_cnt = 0, valid_unlocked = 0;
  bit sb_on = 1'b0, done = 1'b0;
  logic [DW-1:0] exp_s[$], exp_m[$];
  logic [DW-1:0] last_m = '0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // driver: new words whenever a side announces its load edge (R4)
  task automatic drive_step();
    if (!rst && m_ready) begin
      m_tx = {$urandom, $urandom, $urandom};
      exp_s.push_back(m_tx);
      last_m = m_tx;
    end
    if (!rst && s_ready) begin
      s_tx = {$urandom, $urandom, $urandom};
      exp_m.push_back(s_tx);
    end
  endtask

  initial forever begin
    @(negedge clk);
    drive_step();
  end

  // monitor: scoreboard for both directions plus lock observations
  initial forever begin
    logic [DW-1:0] e;
    @(negedge clk);
    if (!rst) begin
      if (s_err) err_cnt++;
      if (s_valid && !s_lock) valid_unlocked++;
      if (sb_on && s_valid) begin
        if (exp_s.size() == 0) check(1'b0, "R5 unexpected word", s_rx, '0);
        else begin e = exp_s.pop_front(); check(s_rx == e, "R5 slave word", s_rx, e); s_cmp++; end
      end
      if (sb_on && m_valid) begin
        if (exp_m.size() == 0) check(1'b0, "R6 unexpected word", m_rx, '0);
        else begin e = exp_m.pop_front(); check(m_rx == e, "R6 master word", m_rx, e); m_cmp++; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wait_m_rise();
    logic p;
    p = m_sync;
    forever begin
      @(negedge clk);
      if (m_sync && !p) break;
      p = m_sync;
    end
  endtask

  task automatic wait_m_fall();
    logic p;
    p = m_sync;
    forever begin
      @(negedge clk);
      if (!m_sync && p) break;
      p = m_sync;
    end
  endtask

  task automatic measure_width(input int w);
    int hi, expw;
    width_m = BW'(w);
    wait_m_rise();
    wait_m_rise();
    hi = 0;
    while (m_sync) begin hi++; @(negedge clk); end
    expw = 8 * ((w == 0) ? 1 : w);
    check(hi == expw, "R3 sync width", DW'(hi), DW'(expw));
  endtask

  initial begin
    int hi, lo, t;
    logic pclk;
    logic [WW-1:0] g0, g1, g2;
    logic [DW-1:0] word;
    width_m = BW'(3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check({m_clk, m_sync, m_data, m_ready, m_valid, m_lock, s_lock, s_err, s_valid} == '0,
          "R9 outputs low in reset", DW'({m_clk, m_sync, m_data, m_ready, m_valid, m_lock}), '0);
    check(m_rx == '0 && s_rx == '0, "R9 rx words low", m_rx | s_rx, '0);
    rst = 1'b0;
    sb_on = 1'b1;

    // R1 bit clock shape and sync alignment
    wait_m_rise();
    wait_m_rise();
    check(m_clk == 1'b1, "R1 sync rises with bit clock", DW'(m_clk), DW'(1));
    hi = 1;
    @(negedge clk);
    while (m_clk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!m_clk) begin lo++; @(negedge clk); end
    check(hi == 4, "R1 bit clock high time", DW'(hi), DW'(4));
    check(lo == 4, "R1 bit clock low time", DW'(lo), DW'(4));
    pclk = m_clk;
    wait_m_rise();
    t = 0;
    forever begin
      @(negedge clk);
      t++;
      if (m_sync && t > 100 && m_clk) break;
    end
    check(t == 256, "R1 frame period", DW'(t), DW'(256));

    // R4 load strobe spacing and width
    while (!m_ready) @(negedge clk);
    t = 0;
    @(negedge clk);
    check(m_ready == 1'b0, "R4 tx_ready one cycle", DW'(m_ready), '0);
    t = 1;
    while (!m_ready) begin t++; @(negedge clk); end
    check(t == 256, "R4 tx_ready once per frame", DW'(t), DW'(256));

    // R2 serial order on the master lanes
    wait_m_rise();
    word = last_m;
    g0 = '0; g1 = '0; g2 = '0;
    for (int k = 0; k < 256; k++) begin
      if (k % 8 == 3) begin
        g0 = {g0[WW-2:0], m_data[0]};
        g1 = {g1[WW-2:0], m_data[1]};
        g2 = {g2[WW-2:0], m_data[2]};
      end
      @(negedge clk);
    end
    check({g2, g1, g0} == word, "R2 MSB-first lane bits", {g2, g1, g0}, word);

    // R3 programmable sync width, including 0
    measure_width(5);
    measure_width(0);
    measure_width(31);
    measure_width(1);
    width_m = BW'(3);

    while (s_cmp < 10 || m_cmp < 10) repeat (256) @(negedge clk);
    check(m_lock == 1'b1, "R7 master locked", DW'(m_lock), DW'(1));
    check(s_lock == 1'b1, "R7 slave locked", DW'(s_lock), DW'(1));
    check(err_cnt == 0, "R8 no error in steady state", DW'(err_cnt), '0);
    sb_on = 1'b0;

    // R8 missing sync pulse
    wait_m_fall();
    kill = 1'b1;
    wait_m_fall();
    kill = 1'b0;
    repeat (20) @(negedge clk);
    check(err_cnt == 1, "R8 missing sync flagged", DW'(err_cnt), DW'(1));
    check(s_lock == 1'b0, "R8 lock cleared on missing sync", DW'(s_lock), '0);
    repeat (4 * 256) @(negedge clk);
    check(s_lock == 1'b1, "R8 relock after missing sync", DW'(s_lock), DW'(1));
    check(err_cnt == 1, "R8 single error pulse", DW'(err_cnt), DW'(1));

    // R8 early sync pulse
    wait_m_fall();
    repeat (100) @(negedge clk);
    inj = 1'b1;
    repeat (3) @(negedge clk);
    inj = 1'b0;
    repeat (5) @(negedge clk);
    check(err_cnt == 2, "R8 early sync flagged", DW'(err_cnt), DW'(2));
    check(s_lock == 1'b0, "R8 lock cleared on early sync", DW'(s_lock), '0);
    repeat (4 * 256) @(negedge clk);
    check(s_lock == 1'b1, "R8 relock after early sync", DW'(s_lock), DW'(1));
    check(valid_unlocked == 0, "R7 no rx_valid while unlocked", DW'(valid_unlocked), '0);
    check(m_err == 1'b0, "R8 master never flags", DW'(m_err), '0);
    if (pclk === 1'bx) n_checks++;
    summary();
  end
endmodule